// File: doc/BRIEF.md
# Write Completion Status Responder

This block sits on the read path of a paged non-volatile memory and tells the host whether an internal programming cycle has finished. While the write controller holds its busy flag, the block replaces two bits in each active byte lane of the read word with status. One is a polling bit that shows the inverse of the last written value, but only on reads of the last written address. The other is a toggle bit that changes value from one read to the next. When busy drops, the read word is passed through unchanged from the array.

The block is combinational from the array word to the read word. Its only state is the toggle flip-flop and a one-cycle copy of the read strobe, used to find the end of each read. The organisation input selects one, two or four byte lanes. Status bits appear only in the selected lanes. A write controller that rejected a write because the array is protected raises the void input, which turns off the polling indication.

Top module: `wc_status`

## Requirements
- R1: After reset the toggle state is 0, so the first read taken while busy shows 0 on bit 6 of every active lane.
- R2: While busy is low, rd_data equals arr_data on every bit.
- R3: While busy is high, void is low and rd_addr equals wr_addr, bit 8*l+7 of rd_data is the inverse of wr_data bit 8*l+7 in every active lane l.
- R4: While busy is high and rd_addr differs from wr_addr, bit 7 of every lane carries arr_data.
- R5: A read is a cycle with cs_n=0, oe_n=0 and we_n=1. While busy is high, bit 8*l+6 of every active lane shows the toggle state. That state inverts once in the clock edge after each read ends with busy high, and it does not change during a read.
- R6: A read ended by raising oe_n alone, or by raising cs_n alone, advances the toggle state just as raising both does.
- R7: A read that ends while busy is low leaves the toggle state unchanged.
- R8: While void is high, bit 7 carries arr_data even on an address match, and the toggle bit keeps working.
- R9: org=00 activates lane 0 only, org=01 activates lanes 0 and 1, and org=10 or 11 activates all four lanes. Inactive lanes carry arr_data on all eight bits.
- R10: Bits 0 to 5 of every lane always carry arr_data.
- R11: A strobe with we_n=0 is not a read and does not advance the toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Programming cycle in progress |
| wr_void | input | 1 | Last write was rejected by protection |
| wr_addr | input | AW | Address of the last written word |
| wr_data | input | 8*LANES | Data of the last written word |
| org | input | 2 | Organisation: 00 x8, 01 x16, 1x x32 |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | AW | Read address |
| arr_data | input | 8*LANES | Word currently stored in the array |
| rd_data | output | 8*LANES | Read word with status substituted |
| rd_active | output | 1 | A read is in progress |

## Verification
The assertions assume that busy, void, the organisation and the last-write address and data stay constant for the whole of each read. They also assume the strobes are high during reset, so the read-end detection never sees a stale strobe. The bench changes these controls only between reads, with the strobes released. It opens and closes every read on the falling clock edge, so each read end is followed by a clear rising edge before the next read begins.

// File: rtl/wc_status.sv
module wc_status #(
  parameter int LANES = 4,
  parameter int AW    = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               wr_void,
  input  logic [AW-1:0]      wr_addr,
  input  logic [8*LANES-1:0] wr_data,
  input  logic [1:0]         org,
  input  logic               cs_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic [AW-1:0]      rd_addr,
  input  logic [8*LANES-1:0] arr_data,
  output logic [8*LANES-1:0] rd_data,
  output logic               rd_active
);
  logic rd_now, rd_q, tgl, hit;

  assign rd_now    = !cs_n && !oe_n && we_n;
  assign rd_active = rd_now;
  assign hit       = busy && !wr_void && (rd_addr == wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tgl  <= 1'b0;
    end else begin
      rd_q <= rd_now;
      if (busy && rd_q && !rd_now) tgl <= ~tgl;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic on;
    if (l == 0) begin : g_base
      assign on = 1'b1;
    end else if (l == 1) begin : g_mid
      assign on = (org != 2'b00);
    end else if (l < 4) begin : g_wide
      assign on = org[1];
    end else begin : g_none
      assign on = 1'b0;
    end
    assign rd_data[8*l +: 6] = arr_data[8*l +: 6];
    assign rd_data[8*l+6]    = (busy && on) ? tgl : arr_data[8*l+6];
    assign rd_data[8*l+7]    = (hit && on) ? ~wr_data[8*l+7] : arr_data[8*l+7];
  end
endmodule

// File: rtl/wc_status_chk.sv
module wc_status_chk #(
  parameter int LANES = 4,
  parameter int AW    = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               wr_void,
  input logic [AW-1:0]      wr_addr,
  input logic [8*LANES-1:0] wr_data,
  input logic [1:0]         org,
  input logic               cs_n,
  input logic               oe_n,
  input logic               we_n,
  input logic [AW-1:0]      rd_addr,
  input logic [8*LANES-1:0] arr_data,
  input logic [8*LANES-1:0] rd_data,
  input logic               rd_active
);
  logic rd;
  assign rd = !cs_n && !oe_n && we_n;

  a_r2_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_data == arr_data);

  a_r3_poll_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wr_void && rd_addr == wr_addr |-> rd_data[7] != wr_data[7]);

  a_r4_miss_passes: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_addr != wr_addr |-> rd_data[7] == arr_data[7]);

  a_r5_steady_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd && $past(rd) && busy && $past(busy) |-> $stable(rd_data[6]));

  a_r8_void_no_poll: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_void |-> rd_data[7] == arr_data[7]);

  a_r9_narrow_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    org == 2'b00 |-> rd_data[8*LANES-1:8] == arr_data[8*LANES-1:8]);

  a_r10_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> rd_data[5:0] == arr_data[5:0]);
endmodule

bind wc_status wc_status_chk #(.LANES(LANES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_void(wr_void), .wr_addr(wr_addr),
  .wr_data(wr_data), .org(org), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data), .rd_active(rd_active)
);

// File: tb/wc_status_bench.sv
module wc_status_bench;
  localparam int AW = 4;
  logic clk = 0, rst_n = 0;
  logic busy = 0, wr_void = 0, cs_n = 1, oe_n = 1, we_n = 1;
  logic [1:0] org = 2'b10;
  logic [AW-1:0] wr_addr = 4'd5, rd_addr = '0;
  logic [31:0] wr_data = 32'h5A3C_C3A5, arr_data = '0, rd_data;
  logic rd_active;
  int checks = 0, errors = 0;
  bit tgl_m = 0, done = 0;

  always #2 clk = ~clk;

  wc_status #(.LANES(4), .AW(AW)) u_wc_status (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_void(wr_void), .wr_addr(wr_addr),
    .wr_data(wr_data), .org(org), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data), .rd_active(rd_active)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(logic [31:0] arr, bit match);
    logic [31:0] w = arr;
    int nl = (org == 2'b00) ? 1 : (org == 2'b01) ? 2 : 4;
    for (int l = 0; l < nl; l++) begin
      if (busy) w[8*l+6] = tgl_m;
      if (busy && !wr_void && match) w[8*l+7] = ~wr_data[8*l+7];
    end
    return w;
  endfunction

  // end_by: 0 both strobes, 1 oe_n alone, 2 cs_n alone
  task automatic do_read(string req, int end_by);
    @(negedge clk); cs_n = 0; oe_n = 0; we_n = 1;
    #1 chk(req, rd_data, expect_word(arr_data, rd_addr == wr_addr));
    @(negedge clk);
    #1 chk(req, rd_data, expect_word(arr_data, rd_addr == wr_addr)); // R5 steady
    @(negedge clk);
    if (end_by == 1) oe_n = 1; else if (end_by == 2) cs_n = 1; else begin cs_n = 1; oe_n = 1; end
    if (busy) tgl_m = ~tgl_m;
    @(negedge clk); cs_n = 1; oe_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    busy = 1; rd_addr = 4'd9; arr_data = 32'hFFFF_FFFF;
    do_read("R1", 0);
    busy = 0;
    for (int o = 0; o < 4; o++)
      for (int b = 0; b < 2; b++)
        for (int v = 0; v < 2; v++)
          for (int a = 0; a < 16; a++) begin
            org = o[1:0]; busy = b[0]; wr_void = v[0]; rd_addr = a[AW-1:0];
            arr_data = {4{a[3:0], 4'(o + b + v)}} ^ 32'h1F2E_3D4C;
            if (!b[0]) do_read("R2", 0);
            else if (v[0]) do_read("R8", a % 3);
            else if (a == 5) do_read("R3", a % 3);
            else if (o == 0) do_read("R9", a % 3);
            else do_read("R4_R10", a % 3);
          end
    org = 2'b10; wr_void = 0; rd_addr = 4'd5; arr_data = 32'h0000_0000;
    busy = 1;
    do_read("R6", 1); do_read("R6", 2); do_read("R6", 1); do_read("R5", 0);
    busy = 0;
    do_read("R7", 0); do_read("R7", 1);
    busy = 1;
    do_read("R7", 0);
    @(negedge clk); cs_n = 0; oe_n = 0; we_n = 0;
    @(negedge clk); @(negedge clk); cs_n = 1; oe_n = 1; we_n = 1;
    do_read("R11", 0);
    busy = 0; arr_data = 32'hA5A5_A5A5;
    do_read("R2", 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule